// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block lets a clocked system read and write an external, unclocked 64K x 8 static RAM. Requests arrive on a valid/ready handshake that carries a read/write flag, a 16-bit address and a write byte. Read results come back as a byte with a one-cycle valid strobe. Toward the memory, the block drives a pair of chip selects of opposite polarity, an output enable, a write enable, the address bus and a tri-state byte data bus.

Every phase of a memory cycle lasts a whole number of clock periods. The counts are worked out at elaboration from the clock period and from the nanosecond limits of the chosen speed grade. The fast grade uses 55/30/55 ns for access, output-enable access and read cycle. It uses 40/50/25/55 ns for write pulse, address-to-write-end, data-to-write-end and write cycle, and 20 ns for bus release. The slow grade uses 70/35/70, 50/60/30/70 and 25. Each count is the ceiling of the limit over the period, and never less than one. When no request is pending, the memory is deselected and the data bus is left floating.

Top module: `sramc_top`

## Requirements
- R1: After reset and whenever no request is in progress, `memSelN` is 1, `memSelP` is 0, `memOeN` and `memWeN` are 1, the data bus is not driven, and `reqReady` is 1.
- R2: The two select pins always sit at opposite levels. The memory counts as selected only when `memSelN` is 0 and `memSelP` is 1.
- R3: An accepted read selects the memory from the next cycle, with `memOeN` 0 and `memWeN` 1, for ACC cycles. ACC is the ceiling of the largest of the access, output-enable access and read-cycle limits over the period, which gives 6 at the fast grade with a 10 ns clock.
- R4: Read data is sampled on the clock edge that ends the ACC-th read cycle. `rdValid` is then 1 for exactly the following cycle, with `rdData` equal to the sampled byte.
- R5: In a write, the memory is selected and `memWeN` is 0 for WP cycles. WP is the ceiling of the largest of the write-pulse, address-to-end and data-to-end limits, which gives 5. After that come cycles that stay selected with `memWeN` at 1, for a total of max(ceil(write cycle), WP+1) cycles, which gives 6. `memOeN` stays 1 throughout, and the bus carries the write byte in every selected write cycle.
- R6: The controller drives the data bus only once REL cycles have passed since `memOeN` last rose, where REL is the ceiling of the release limit (2). A write accepted before then waits with the memory deselected.
- R7: `reqReady` is 0 from the cycle after an acceptance until that memory cycle completes. A request presented while it is 0 is not taken.
- R8: `memAddr` holds steady in every cycle in which the memory stays selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 8 | Byte to write |
| rdValid | output | 1 | One-cycle strobe: rdData is valid |
| rdData | output | 8 | Byte read from memory |
| memSelN | output | 1 | Active-low chip select |
| memSelP | output | 1 | Active-high chip select |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memAddr | output | 16 | Memory address bus |
| memData | inout | 8 | Memory data bus, tri-state |

## Verification
The two functions that can fall in the same cycle are the delivery of a finished read (the `rdValid` strobe and the start of the bus-release count) and the acceptance of a write that has to wait out that release before it may drive the bus. The case is provoked by holding a write request valid while a read is still running, so that the write is taken in the first idle cycle. A behavioural model then predicts every pin in every cycle: the deselected wait cycle, the late fall of write enable, and the strobe itself. The bench compares the design against that prediction on each clock.

// File: rtl/sramc_pkg.sv
`timescale 1ns/1ps
package sramc_pkg;

  typedef enum logic [2:0] {
    LIM_ACCESS, LIM_OE_ACCESS, LIM_READ_CYCLE, LIM_WRITE_CYCLE,
    LIM_WE_PULSE, LIM_ADDR_TO_WEND, LIM_DATA_TO_WEND, LIM_RELEASE
  } limit_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WAIT, ST_WPULSE, ST_WHOLD
  } ctrlState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic selChip;
    logic readOut;
    logic writePulse;
    logic driveBus;
    logic capture;
  } memStrobe_t;

  // Nanosecond limit for a grade: 0 = fast, anything else = slow
  function automatic int limitNs(int grade, limit_e lim);
    logic fast;
    fast = (grade == 0);
    case (lim)
      LIM_ACCESS:       return fast ? 55 : 70;
      LIM_OE_ACCESS:    return fast ? 30 : 35;
      LIM_READ_CYCLE:   return fast ? 55 : 70;
      LIM_WRITE_CYCLE:  return fast ? 55 : 70;
      LIM_WE_PULSE:     return fast ? 40 : 50;
      LIM_ADDR_TO_WEND: return fast ? 50 : 60;
      LIM_DATA_TO_WEND: return fast ? 25 : 30;
      default:          return fast ? 20 : 25;
    endcase
  endfunction

  function automatic int toCycles(int ns, int periodNs);
    int c;
    c = (periodNs < 1) ? ns : (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_ctrl.sv
`timescale 1ns/1ps
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int ACC_CYC    = 6,
  parameter int WPULSE_CYC = 5,
  parameter int WHOLD_CYC  = 1,
  parameter int REL_CYC    = 2,
  parameter int CNT_W      = 3,
  parameter int REL_W      = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output memStrobe_t strobe
);

  localparam logic [CNT_W-1:0] ACC_LAST   = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(WPULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(WHOLD_CYC - 1);
  localparam logic [REL_W-1:0] REL_LOAD   = REL_W'(REL_CYC);
  localparam logic [REL_W-1:0] REL_ONE    = REL_W'(1);

  ctrlState_e state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [REL_W-1:0] relCnt;
  logic relDone;

  // Bus is free by the next cycle when at most one release cycle remains
  assign relDone = (relCnt <= REL_ONE);

  always_comb begin
    stateNxt = state;
    cntNxt   = (cnt != '0) ? cnt - 1'b1 : cnt;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (!reqWrite) begin
            stateNxt = ST_READ;
            cntNxt   = ACC_LAST;
          end else if (relDone) begin
            stateNxt = ST_WPULSE;
            cntNxt   = PULSE_LAST;
          end else begin
            stateNxt = ST_WAIT;
          end
        end
      end
      ST_READ: begin
        if (cnt == '0) stateNxt = ST_IDLE;
      end
      ST_WAIT: begin
        if (relDone) begin
          stateNxt = ST_WPULSE;
          cntNxt   = PULSE_LAST;
        end
      end
      ST_WPULSE: begin
        if (cnt == '0) begin
          stateNxt = ST_WHOLD;
          cntNxt   = HOLD_LAST;
        end
      end
      ST_WHOLD: begin
        if (cnt == '0) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      relCnt <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
      if (strobe.capture)    relCnt <= REL_LOAD;
      else if (relCnt != '0) relCnt <= relCnt - 1'b1;
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.loadReq    = (state == ST_IDLE) && reqValid;
    strobe.selChip    = (state == ST_READ) || (state == ST_WPULSE) || (state == ST_WHOLD);
    strobe.readOut    = (state == ST_READ);
    strobe.writePulse = (state == ST_WPULSE);
    strobe.driveBus   = (state == ST_WPULSE) || (state == ST_WHOLD);
    strobe.capture    = (state == ST_READ) && (cnt == '0);
  end

  assign reqReady = (state == ST_IDLE);

  // R6: own drivers only after the release window has run out
  assert_drive_after_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.driveBus |-> (relCnt == '0));

  // R1: ready implies memory deselected and bus released
  assert_ready_deselected_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!strobe.selChip && !strobe.driveBus));

  // R4: sampling happens only inside a read with output enable on
  assert_capture_in_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> (strobe.readOut && !strobe.writePulse));

endmodule

// File: rtl/sramc_dpath.sv
`timescale 1ns/1ps
module sramc_dpath
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              memSelN,
  output logic              memSelP,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memData
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (strobe.loadReq) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
      end
      if (strobe.capture) rdData <= memData;
      rdValid <= strobe.capture;
    end
  end

  assign memSelN = ~strobe.selChip;
  assign memSelP =  strobe.selChip;
  assign memOeN  = ~strobe.readOut;
  assign memWeN  = ~strobe.writePulse;
  assign memAddr = addrReg;
  assign memData = strobe.driveBus ? wdataReg : {DATA_W{1'bz}};

  // R4: valid strobe lasts one cycle
  assert_rdvalid_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R5: write enable low only while selected and output enable high
  assert_write_oe_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && !memSelN && memSelP));

  // R5: the write ends with the memory still selected
  assert_write_end_selected_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> !memSelN);

  // R6: never drive against a memory whose outputs are enabled
  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.driveBus |-> memOeN);

  // R8: address steady across a selected stretch
  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!memSelN && $past(!memSelN)) |-> $stable(memAddr));

endmodule

// File: rtl/sramc_top.sv
`timescale 1ns/1ps
module sramc_top
  import sramc_pkg::*;
#(
  parameter int SPEED_GRADE   = 0,
  parameter int CLK_PERIOD_NS = 10,
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              memSelN,
  output logic              memSelP,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memData
);

  localparam int ACC_CYC = maxOf(
    maxOf(toCycles(limitNs(SPEED_GRADE, LIM_ACCESS), CLK_PERIOD_NS),
          toCycles(limitNs(SPEED_GRADE, LIM_OE_ACCESS), CLK_PERIOD_NS)),
    toCycles(limitNs(SPEED_GRADE, LIM_READ_CYCLE), CLK_PERIOD_NS));
  localparam int WPULSE_CYC = maxOf(
    maxOf(toCycles(limitNs(SPEED_GRADE, LIM_WE_PULSE), CLK_PERIOD_NS),
          toCycles(limitNs(SPEED_GRADE, LIM_ADDR_TO_WEND), CLK_PERIOD_NS)),
    toCycles(limitNs(SPEED_GRADE, LIM_DATA_TO_WEND), CLK_PERIOD_NS));
  localparam int WTOTAL_CYC = maxOf(
    toCycles(limitNs(SPEED_GRADE, LIM_WRITE_CYCLE), CLK_PERIOD_NS), WPULSE_CYC + 1);
  localparam int WHOLD_CYC = WTOTAL_CYC - WPULSE_CYC;
  localparam int REL_CYC   = toCycles(limitNs(SPEED_GRADE, LIM_RELEASE), CLK_PERIOD_NS);
  localparam int CNT_W     = $clog2(maxOf(ACC_CYC, maxOf(WPULSE_CYC, WHOLD_CYC)) + 1);
  localparam int REL_W     = $clog2(REL_CYC + 1);

  memStrobe_t strobe;

  sramc_ctrl #(
    .ACC_CYC   (ACC_CYC),
    .WPULSE_CYC(WPULSE_CYC),
    .WHOLD_CYC (WHOLD_CYC),
    .REL_CYC   (REL_CYC),
    .CNT_W     (CNT_W),
    .REL_W     (REL_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strobe  (strobe)
  );

  sramc_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .rdValid (rdValid),
    .rdData  (rdData),
    .memSelN (memSelN),
    .memSelP (memSelP),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .memAddr (memAddr),
    .memData (memData)
  );

endmodule

// File: tb/sramc_top_bench.sv
`timescale 1ns/1ps
module sramc_top_bench;

  localparam int GRADE = 0;
  localparam int PER   = 10;

  function automatic int ceilCyc(int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int big(int a, int b);
    return (a > b) ? a : b;
  endfunction

  int ACC, WPC, WTOT, REL;

  logic clk = 1'b0;
  logic rstN;
  logic reqValid, reqWrite;
  logic [15:0] reqAddr;
  logic [7:0] reqWdata;
  wire  reqReady, rdValid, memSelN, memSelP, memOeN, memWeN;
  wire  [7:0] rdData;
  wire  [15:0] memAddr;
  wire  [7:0] memData;

  always #5 clk = ~clk;

  sramc_top #(.SPEED_GRADE(GRADE), .CLK_PERIOD_NS(PER)) u_sramc_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .memSelN(memSelN), .memSelP(memSelP),
    .memOeN(memOeN), .memWeN(memWeN), .memAddr(memAddr), .memData(memData)
  );

  // Behavioural memory, indexed by a folded address
  logic [7:0] devMem [0:4095];
  logic [7:0] refMem [0:4095];
  wire  [11:0] busIdx = {memAddr[15], memAddr[10:0]};
  wire  memDrives = !memSelN && memSelP && !memOeN && memWeN;
  assign memData = memDrives ? devMem[busIdx] : 8'bz;

  function automatic logic [11:0] foldIdx(logic [15:0] a);
    return {a[15], a[10:0]};
  endfunction

  typedef struct packed {
    logic sel; logic oeLow; logic weLow; logic drv; logic lastRead;
    logic [15:0] addr; logic [7:0] data;
  } expCyc_t;

  typedef struct packed {
    logic wr; logic [15:0] addr; logic [7:0] data; logic [3:0] gap;
  } req_t;

  expCyc_t expQ[$];
  req_t    reqQ[$];
  int      relLeft = 0;
  int      gapLeft = 0;
  logic    expRdValid = 1'b0;
  logic [7:0] expRdata = '0;
  int nChecks = 0, nFail = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic addReq(bit wr, logic [15:0] a, logic [7:0] d, int gap);
    req_t r;
    r.wr = wr; r.addr = a; r.data = d; r.gap = 4'(gap);
    reqQ.push_back(r);
  endtask

  task automatic compareNow();
    expCyc_t e;
    bit busy;
    string tg;
    busy = (expQ.size() != 0);
    e = busy ? expQ[0] : '0;
    tg = !busy ? "R1" : (e.oeLow ? "R3" : ((e.weLow || e.sel) ? "R5" : "R6"));
    check(memSelN == !e.sel, tg, "active-low select", memSelN, !e.sel);
    check(memSelP == e.sel, "R2", "active-high select", memSelP, e.sel);
    check(memOeN == !e.oeLow, tg, "output enable", memOeN, !e.oeLow);
    check(memWeN == !e.weLow, tg, "write enable", memWeN, !e.weLow);
    check(reqReady == !busy, "R7", "ready", reqReady, !busy);
    if (e.sel) check(memAddr == e.addr, "R8", "address", memAddr, e.addr);
    if (e.drv) check(memData == e.data, "R5", "write bus", memData, e.data);
    check(rdValid == expRdValid, "R4", "read valid", rdValid, expRdValid);
    if (expRdValid) check(rdData == expRdata, "R4", "read data", rdData, expRdata);
    if (!memSelN && memSelP && !memWeN) devMem[busIdx] = memData;
  endtask

  task automatic driveNext();
    if (reqQ.size() == 0) begin
      reqValid = 1'b0;
    end else if (gapLeft > 0) begin
      reqValid = 1'b0;
      gapLeft--;
    end else begin
      reqValid = 1'b1;
      reqWrite = reqQ[0].wr;
      reqAddr  = reqQ[0].addr;
      reqWdata = reqQ[0].data;
    end
  endtask

  task automatic stepCycle();
    bit readyPre, accept;
    int relPre, waitCyc;
    expCyc_t p, n;
    req_t r;
    readyPre = (expQ.size() == 0);
    relPre   = relLeft;
    accept   = reqValid && readyPre;
    @(posedge clk);
    expRdValid = 1'b0;
    if (!readyPre) begin
      p = expQ.pop_front();
      if (p.lastRead) begin
        relLeft    = REL;
        expRdValid = 1'b1;
        expRdata   = refMem[foldIdx(p.addr)];
      end else if (relLeft > 0) relLeft--;
    end else if (relLeft > 0) relLeft--;
    if (accept) begin
      r = reqQ.pop_front();
      if (reqQ.size() != 0) gapLeft = int'(reqQ[0].gap);
      if (!r.wr) begin
        for (int i = 0; i < ACC; i++) begin
          n = '0; n.sel = 1; n.oeLow = 1; n.addr = r.addr; n.lastRead = (i == ACC - 1);
          expQ.push_back(n);
        end
      end else begin
        refMem[foldIdx(r.addr)] = r.data;
        waitCyc = (relPre > 1) ? relPre - 1 : 0;
        for (int i = 0; i < waitCyc; i++) expQ.push_back('0);
        for (int i = 0; i < WTOT; i++) begin
          n = '0; n.sel = 1; n.drv = 1; n.weLow = (i < WPC);
          n.addr = r.addr; n.data = r.data;
          expQ.push_back(n);
        end
      end
    end
    @(negedge clk);
    compareNow();
    driveNext();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    ACC  = big(big(ceilCyc(GRADE == 0 ? 55 : 70), ceilCyc(GRADE == 0 ? 30 : 35)),
               ceilCyc(GRADE == 0 ? 55 : 70));
    WPC  = big(big(ceilCyc(GRADE == 0 ? 40 : 50), ceilCyc(GRADE == 0 ? 50 : 60)),
               ceilCyc(GRADE == 0 ? 25 : 30));
    WTOT = big(ceilCyc(GRADE == 0 ? 55 : 70), WPC + 1);
    REL  = ceilCyc(GRADE == 0 ? 20 : 25);
    for (int i = 0; i < 4096; i++) begin
      devMem[i] = 8'(i) ^ {4'(i >> 8), 4'(i >> 8)} ^ 8'h5A;
      refMem[i] = devMem[i];
    end
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0;
    // R1: state held during reset
    repeat (3) @(negedge clk);
    compareNow();
    rstN = 1'b1;
    // R3/R4 plain read-after-write; R6 write held during a read, taken as rdValid fires
    addReq(1, 16'h1234, 8'h3C, 2);
    addReq(0, 16'h1234, 8'h00, 0);
    addReq(1, 16'h0000, 8'hE1, 0);
    addReq(0, 16'h0000, 8'h00, 0);
    // R4 unwritten top address, then boundary write and readback
    addReq(0, 16'hFFFF, 8'h00, 0);
    addReq(1, 16'hFFFF, 8'h7E, 3);
    addReq(0, 16'hFFFF, 8'h00, 0);
    // R7 back-to-back reads and writes
    addReq(0, 16'h0042, 8'h00, 0);
    addReq(1, 16'h0042, 8'h99, 0);
    addReq(1, 16'h0043, 8'h18, 0);
    addReq(0, 16'h0042, 8'h00, 0);
    addReq(0, 16'h0043, 8'h00, 1);
    lf = 16'hACE1;
    for (int k = 0; k < 160; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      addReq(lf[0], {lf[9], 4'b0, 3'b0, lf[15:8]}, lf[7:0] ^ 8'hC3, int'(lf[3:2]) % 3);
    end
    gapLeft = int'(reqQ[0].gap);
    driveNext();
    while (reqQ.size() != 0 || expQ.size() != 0) stepCycle();
    repeat (4) stepCycle();
    finished = 1;
    summary();
    $finish;
  end

endmodule